// File: doc/BRIEF.md
# Nibble-Packed Sample FIFO

This block is a circular byte buffer for audio samples. A host fills it one byte per write, and each byte holds two 4-bit nibbles. The playback side drains it as a nibble stream. Each pull assembles one sample of 1, 2, 3 or 4 nibbles, as a configuration field selects. The assembled sample is aligned and sign-justified into a 12-bit signed output.

The buffer tracks its byte occupancy, so the empty and full states are never confused. It flags writes that arrive while the buffer is full. From the free space and a programmable threshold it derives a request level. The sense of that comparison depends on whether the channel is in playback or record mode, and a mask bit gates the interrupt copy of the request. A falling edge on the channel reset input flushes the buffer.

Top module: `nibble_sample_fifo`

## Requirements
- R1: After rst_n is released, empty is 1, full and overflow are 0, smp_valid is 0 and smp_out is 0.
- R2: Each accepted wr_en stores one byte (two nibbles). empty clears after the first byte, and full rises once DEPTH (128) bytes are held.
- R3: A wr_en while full sets the sticky overflow flag and drops the byte. The held data and count stay unchanged, and a later flush is the only thing that clears overflow.
- R4: Nibbles leave each byte high nibble first, then low nibble. The read position moves to the next byte only after the low nibble is taken.
- R5: The format field cfg_data[6:5] gives the nibbles per sample: 0 means 2, 1 means 3, 2 means 4 and 3 means 1. The sample goes out as a 12-bit word. A 1-nibble sample is placed in bits 11:8 and a 2-nibble sample in bits 11:4, with the rest zero. A 3-nibble sample is output as is. For a 4-nibble sample the top 12 of its 16 bits are output.
- R6: A pull when fewer nibbles are held than the format needs returns a zero sample and leaves the buffer untouched. This includes a pull from an empty buffer.
- R7: The threshold is (cfg_data[4:2] + 1) x 16 bytes. With mode_play = 1, req is 1 exactly when the free bytes exceed the threshold.
- R8: With mode_play = 0, req is 1 exactly when the free bytes are fewer than the threshold.
- R9: cfg_data[1] masks the interrupt. irq follows req when this bit is 0 and stays 0 when it is 1.
- R10: A 1-to-0 transition of chan_rst empties the buffer, clears the nibble position and clears overflow.
- R11: smp_valid pulses for exactly one cycle, the cycle after each rd_req, with smp_out holding that pull's sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the control field from cfg_data |
| cfg_data | input | 8 | Control: [6:5] format, [4:2] threshold step, [1] interrupt mask |
| mode_play | input | 1 | 1 for playback sense of the request, 0 for record sense |
| chan_rst | input | 1 | Channel reset level; its falling edge flushes |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| rd_req | input | 1 | Pull one assembled sample |
| smp_valid | output | 1 | Sample strobe, one cycle after rd_req |
| smp_out | output | 12 | Aligned signed sample |
| empty | output | 1 | No bytes held |
| full | output | 1 | DEPTH bytes held |
| overflow | output | 1 | Sticky write-while-full flag |
| req | output | 1 | Free-space threshold request |
| irq | output | 1 | Request after the mask |

## Verification
The embedded properties take for granted that rst_n is held low on the first clock edges. They also assume that every input has a known value at each rising edge. They make no assumption about how reads, writes, configuration changes and flushes overlap, since the design defines each combination. The bench changes inputs only on falling edges and holds chan_rst high for a full cycle before each release. It reads a sample's result only in the cycle after its request, so every sampled value comes from a settled state.

// File: rtl/nibble_sample_fifo.sv
module nibble_sample_fifo #(
  parameter int DEPTH    = 128,
  parameter int THR_STEP = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_data,
  input  logic        mode_play,
  input  logic        chan_rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_req,
  output logic        smp_valid,
  output logic [11:0] smp_out,
  output logic        empty,
  output logic        full,
  output logic        overflow,
  output logic        req,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = CW + 4;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          ph;
  logic [1:0]    fmt_q;
  logic [2:0]    thr_q;
  logic          msk_q;
  logic          chan_q;

  logic          flush, wr_ok, rd_ok;
  logic [2:0]    need, adv;
  logic [CW:0]   avail;
  logic [23:0]   win, sh;
  logic [11:0]   sample;
  logic [TW-1:0] free_b, thr_b;

  assign flush  = chan_q & ~chan_rst;
  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign need   = (fmt_q == 2'd3) ? 3'd1 : {1'b0, fmt_q} + 3'd2;
  assign avail  = {cnt, 1'b0} - (CW+1)'(ph);
  assign wr_ok  = wr_en & ~full & ~flush;
  assign rd_ok  = rd_req & ~flush & (avail >= (CW+1)'(need));
  assign adv    = {2'b0, ph} + need;

  assign win    = {mem[rp], mem[rp + AW'(1)], mem[rp + AW'(2)]};
  assign sh     = ph ? {win[19:0], 4'h0} : win;
  assign sample = (need == 3'd1) ? {sh[23:20], 8'h00} :
                  (need == 3'd2) ? {sh[23:16], 4'h0}  : sh[23:12];

  assign free_b = TW'(DEPTH) - TW'(cnt);
  assign thr_b  = (TW'(thr_q) + TW'(1)) * TW'(THR_STEP);
  assign req    = mode_play ? (free_b > thr_b) : (free_b < thr_b);
  assign irq    = req & ~msk_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ph <= 1'b0;
      fmt_q <= '0; thr_q <= '0; msk_q <= 1'b0;
      chan_q <= 1'b1; overflow <= 1'b0;
      smp_valid <= 1'b0; smp_out <= '0;
    end else begin
      chan_q    <= chan_rst;
      smp_valid <= rd_req;
      smp_out   <= rd_ok ? sample : 12'h000;
      if (cfg_wr) begin
        fmt_q <= cfg_data[6:5];
        thr_q <= cfg_data[4:2];
        msk_q <= cfg_data[1];
      end
      if (flush) begin
        wp <= '0; rp <= '0; cnt <= '0; ph <= 1'b0;
        overflow <= 1'b0;
      end else begin
        if (wr_en && full) overflow <= 1'b1;
        if (wr_ok) wp <= wp + AW'(1);
        if (rd_ok) begin
          rp <= rp + AW'(adv[2:1]);
          ph <= adv[0];
        end
        cnt <= cnt + CW'(wr_ok) - (rd_ok ? CW'(adv[2:1]) : CW'(0));
      end
    end
  end

  assert_empty_full_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  assert_full_write_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_req && !flush |=> full && overflow);
  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flush |=> overflow);
  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && empty && !wr_en |=> smp_out == 12'h000 && empty);
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !overflow);
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> smp_valid);
  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !smp_valid);
endmodule

// File: tb/nibble_sample_fifo_bench.sv
module nibble_sample_fifo_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic mode_play = 1'b1;
  logic chan_rst = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rd_req = 1'b0;
  logic smp_valid, empty, full, overflow, req, irq;
  logic [11:0] smp_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nibble_sample_fifo u_nibble_sample_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .mode_play(mode_play), .chan_rst(chan_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_req(rd_req), .smp_valid(smp_valid), .smp_out(smp_out), .empty(empty),
    .full(full), .overflow(overflow), .req(req), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [11:0] s);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check("R11 smp_valid", smp_valid, 1);
    s = smp_out;
  endtask

  task automatic t_reset;
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 overflow", overflow, 0);
    check("R1 smp_valid", smp_valid, 0);
    check("R1 smp_out", smp_out, 0);
  endtask

  task automatic t_nibble_order;
    logic [11:0] s;
    cfg(8'h60);
    wr(8'hA5);
    check("R2 empty after write", empty, 0);
    rd(s); check("R4 high nibble first", s, 12'hA00);
    check("R4 byte kept after high nibble", empty, 0);
    rd(s); check("R4 low nibble second", s, 12'h500);
    check("R4 byte released", empty, 1);
    @(negedge clk);
    check("R11 valid single cycle", smp_valid, 0);
  endtask

  task automatic t_formats;
    logic [11:0] s;
    cfg(8'h00); wr(8'h9C);
    rd(s); check("R5 fmt0 two nibbles", s, 12'h9C0);
    cfg(8'h20); wr(8'h12); wr(8'h34);
    rd(s); check("R5 fmt1 three nibbles", s, 12'h123);
    rd(s); check("R6 short read zero", s, 12'h000);
    cfg(8'h60);
    rd(s); check("R6 short read left data", s, 12'h400);
    cfg(8'h40); wr(8'hFE); wr(8'hDC);
    rd(s); check("R5 fmt2 four nibbles", s, 12'hFED);
    cfg(8'h60); wr(8'h12);
    rd(s); check("R4 odd phase first", s, 12'h100);
    cfg(8'h40); wr(8'h34); wr(8'h56);
    rd(s); check("R5 fmt2 across bytes", s, 12'h234);
    cfg(8'h60);
    rd(s); check("R4 odd phase tail", s, 12'h600);
    check("R2 drained", empty, 1);
    rd(s); check("R6 empty read zero", s, 12'h000);
    check("R6 empty stays", empty, 1);
  endtask

  task automatic t_threshold_fill;
    logic [11:0] s;
    cfg(8'h04);
    for (int k = 0; k < 95; k++) wr(8'(k));
    check("R7 play free 33 > 32", req, 1);
    check("R9 irq follows", irq, 1);
    wr(8'd95);
    check("R7 play free 32 not above", req, 0);
    @(negedge clk); mode_play = 1'b0; #1;
    check("R8 rec free 32 not below", req, 0);
    wr(8'd96);
    check("R8 rec free 31 below", req, 1);
    cfg(8'h06);
    check("R9 masked irq", irq, 0);
    check("R9 req unmasked", req, 1);
    cfg(8'h04);
    check("R9 unmasked irq", irq, 1);
    for (int k = 97; k < 128; k++) wr(8'(k));
    check("R2 full", full, 1);
    check("R3 no overflow yet", overflow, 0);
    wr(8'hEE);
    check("R3 overflow set", overflow, 1);
    check("R3 still full", full, 1);
    @(negedge clk); mode_play = 1'b1;
    rd(s); check("R3 first byte intact", s, 12'h000);
    for (int k = 1; k < 127; k++) rd(s);
    rd(s); check("R3 last byte not replaced", s, 12'h7F0);
    check("R3 dropped byte absent", empty, 1);
    check("R3 overflow sticky", overflow, 1);
  endtask

  task automatic t_flush;
    wr(8'h11); wr(8'h22);
    cfg(8'h60);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk); chan_rst = 1'b1;
    @(negedge clk);
    check("R10 high level keeps data", empty, 0);
    chan_rst = 1'b0;
    @(negedge clk);
    check("R10 flushed empty", empty, 1);
    check("R10 overflow cleared", overflow, 0);
    wr(8'h3C);
    begin
      logic [11:0] s;
      rd(s); check("R10 phase cleared", s, 12'h300);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nibble_order();
    t_formats();
    t_threshold_fill();
    t_flush();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule